// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block keeps the pending-event flags of three timer/counters in one byte-wide status register. Each timer delivers single-cycle pulses for its events: compare matches for all three timers, overflows for timers 0 and 2, and an input capture for timer 1. A pulse sets the matching flag. The flag then stays set until one of two things clears it: software writes a 1 to that bit, or the interrupt controller acknowledges that flag's vector.

Each flag drives its own interrupt request. A request is a registered level. It is high only while the flag, that flag's enable bit and the global interrupt enable are all 1.

The two overflow flags have a mode input, one per timer. In normal mode an overflow flag is set by the counter's wrap pulse. In PWM mode it is set instead by the pulse the counter gives when it moves away from 0x00.

Top module: `tif_flag_reg`

## Requirements
- R1: The flags sit at fixed bit positions in `bus_rdata`: bit 0 timer 0 compare, bit 1 timer 0 overflow, bit 2 timer 2 compare, bit 3 timer 1 capture, bit 4 timer 2 overflow, bit 5 timer 1 compare B, bit 6 timer 1 compare A. An event pulse in cycle N makes its bit read 1 after clock edge N, and the bit stays 1 while nothing clears it.
- R2: With `bus_we` high, each 1 in `bus_wdata[6:0]` clears the matching flag at that edge. Each 0 leaves its flag unchanged.
- R3: A pulse on `irq_ack[i]` clears flag i at that edge. The other flags are not affected.
- R4: When a set event and a clear (write-1 or acknowledge) reach the same flag in the same cycle, the flag ends up 1.
- R5: `irq_req[i]` goes high one edge after flag i, `irq_en[i]` and `gie` are all 1. It is never high unless flag i was 1 at the previous edge.
- R6: `irq_req[i]` falls one edge after flag i clears, or one edge after `irq_en[i]` or `gie` drops.
- R7: In normal mode (`t0_pwm`/`t2_pwm` = 0), the overflow flag is set by the wrap pulse. The leave-zero pulse has no effect on it.
- R8: In PWM mode (`t0_pwm`/`t2_pwm` = 1), the overflow flag is set by the leave-zero pulse. The wrap pulse has no effect on it.
- R9: Bit 7 of `bus_rdata` always reads 0, and writing 1 to bit 7 changes nothing.
- R10: A synchronous active-high `rst` clears all flags and all interrupt requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data; a 1 clears the matching flag |
| bus_rdata | output | 8 | Flag byte as read by software |
| t0_cmp_evt | input | 1 | Timer 0 compare-match pulse |
| t0_wrap_evt | input | 1 | Timer 0 wrap pulse |
| t0_leave0_evt | input | 1 | Timer 0 pulse for the count leaving 0x00 |
| t0_pwm | input | 1 | Timer 0 is in PWM mode |
| t1_cmpa_evt | input | 1 | Timer 1 compare A pulse |
| t1_cmpb_evt | input | 1 | Timer 1 compare B pulse |
| t1_capt_evt | input | 1 | Timer 1 count copied to the capture register |
| t2_cmp_evt | input | 1 | Timer 2 compare-match pulse |
| t2_wrap_evt | input | 1 | Timer 2 wrap pulse |
| t2_leave0_evt | input | 1 | Timer 2 pulse for the count leaving 0x00 |
| t2_pwm | input | 1 | Timer 2 is in PWM mode |
| irq_en | input | 7 | Per-flag interrupt enables, same bit positions as the flags |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 7 | Vector acknowledge pulses, one per flag |
| irq_req | output | 7 | Per-flag interrupt requests |

## Verification
The hardest case to reach is a collision: a set event and a clear arriving at the same flag in the same cycle. A collision through software writes and one through an acknowledge both have to be covered. The stimulus table builds both. It drives a write-1 over the whole register, or an acknowledge pulse, in the same cycle as a compare pulse for one of the bits being cleared. It then checks that only that bit survives.

The PWM overflow source is also awkward to see. The table sends wrap pulses while a timer is in PWM mode, and leave-zero pulses while it is not, so that a wrongly selected source shows up as a stray flag.

// File: rtl/tif_pkg.sv
package tif_pkg;

    // number of implemented flags; the register byte carries one spare bit
    parameter int unsigned NFLAG = 7;
    localparam int unsigned REG_W = NFLAG + 1;

    // bit positions in the software-visible byte (decoded by software)
    localparam int unsigned POS_T0_CMP  = 0;
    localparam int unsigned POS_T0_OVF  = 1;
    localparam int unsigned POS_T2_CMP  = 2;
    localparam int unsigned POS_T1_CAP  = 3;
    localparam int unsigned POS_T2_OVF  = 4;
    localparam int unsigned POS_T1_CMPB = 5;
    localparam int unsigned POS_T1_CMPA = 6;

    typedef logic [NFLAG-1:0] flag_vec_t;
    typedef logic [REG_W-1:0] reg_byte_t;

    // which timer pulse feeds an overflow flag
    typedef enum logic {
        OVF_ON_WRAP   = 1'b0,
        OVF_ON_LEAVE0 = 1'b1
    } ovf_mode_e;

    typedef struct packed {
        logic wrap;
        logic leave0;
    } ovf_evt_t;

    // member order follows the bit positions, MSB first
    typedef struct packed {
        logic t1_cmpa;
        logic t1_cmpb;
        logic t2_ovf;
        logic t1_cap;
        logic t2_cmp;
        logic t0_ovf;
        logic t0_cmp;
    } flag_src_t;

    function automatic flag_vec_t src_to_vec(flag_src_t s);
        return flag_vec_t'(s);
    endfunction

    function automatic reg_byte_t vec_to_byte(flag_vec_t f);
        return {1'b0, f};
    endfunction

    function automatic ovf_mode_e mode_of(logic pwm);
        return pwm ? OVF_ON_LEAVE0 : OVF_ON_WRAP;
    endfunction

endpackage

// File: rtl/tif_ovf_sel.sv
module tif_ovf_sel
    import tif_pkg::*;
(
    input  ovf_mode_e mode,
    input  ovf_evt_t  evt,
    output logic      set_o
);

    always_comb begin
        unique case (mode)
            OVF_ON_WRAP:   set_o = evt.wrap;
            OVF_ON_LEAVE0: set_o = evt.leave0;
            default:       set_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R2
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

    // R1
    flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(flag_o));

endmodule

// File: rtl/tif_irq_gate.sv
module tif_irq_gate
    import tif_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      gie,
    input  flag_vec_t en,
    input  flag_vec_t flags,
    output flag_vec_t irq_o
);

    flag_vec_t irq_q;

    for (genvar i = 0; i < NFLAG; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) irq_q[i] <= 1'b0;
            else     irq_q[i] <= gie & en[i] & flags[i];
        end
    end

    assign irq_o = irq_q;

    // R5
    req_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((irq_o & ~$past(flags)) == '0));

    // R6
    gie_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !gie |=> (irq_o == '0));

endmodule

// File: rtl/tif_flag_reg.sv
module tif_flag_reg
    import tif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       t0_cmp_evt,
    input  logic       t0_wrap_evt,
    input  logic       t0_leave0_evt,
    input  logic       t0_pwm,
    input  logic       t1_cmpa_evt,
    input  logic       t1_cmpb_evt,
    input  logic       t1_capt_evt,
    input  logic       t2_cmp_evt,
    input  logic       t2_wrap_evt,
    input  logic       t2_leave0_evt,
    input  logic       t2_pwm,
    input  logic [6:0] irq_en,
    input  logic       gie,
    input  logic [6:0] irq_ack,
    output logic [6:0] irq_req
);

    ovf_evt_t  t0_ovf_evt, t2_ovf_evt;
    logic      t0_ovf_set, t2_ovf_set;
    flag_src_t src;
    flag_vec_t set_vec, clr_vec, wr_clr, flags;
    logic      unused_wmsb;

    assign unused_wmsb = bus_wdata[7];

    assign t0_ovf_evt = '{wrap: t0_wrap_evt, leave0: t0_leave0_evt};
    assign t2_ovf_evt = '{wrap: t2_wrap_evt, leave0: t2_leave0_evt};

    tif_ovf_sel u_t0_ovf (
        .mode  (mode_of(t0_pwm)),
        .evt   (t0_ovf_evt),
        .set_o (t0_ovf_set)
    );

    tif_ovf_sel u_t2_ovf (
        .mode  (mode_of(t2_pwm)),
        .evt   (t2_ovf_evt),
        .set_o (t2_ovf_set)
    );

    always_comb begin
        src.t0_cmp  = t0_cmp_evt;
        src.t0_ovf  = t0_ovf_set;
        src.t2_cmp  = t2_cmp_evt;
        src.t1_cap  = t1_capt_evt;
        src.t2_ovf  = t2_ovf_set;
        src.t1_cmpb = t1_cmpb_evt;
        src.t1_cmpa = t1_cmpa_evt;
    end

    assign set_vec = src_to_vec(src);
    assign wr_clr  = bus_we ? bus_wdata[NFLAG-1:0] : '0;
    assign clr_vec = wr_clr | irq_ack;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        tif_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flags[i])
        );
    end

    tif_irq_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .gie   (gie),
        .en    (irq_en),
        .flags (flags),
        .irq_o (irq_req)
    );

    assign bus_rdata = vec_to_byte(flags);

    // R2
    write_zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && set_vec == '0 && irq_ack == '0)
        |=> (bus_rdata[6:0] == ($past(bus_rdata[6:0]) & ~$past(bus_wdata[6:0]))));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack[POS_T1_CMPA] && !t1_cmpa_evt) |=> !bus_rdata[POS_T1_CMPA]);

    // R8
    pwm_wrap_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (t0_pwm && t0_wrap_evt && !t0_leave0_evt && !bus_rdata[POS_T0_OVF]
         && irq_ack[POS_T0_OVF] == 1'b0) |=> !bus_rdata[POS_T0_OVF]);

    // R7
    wrap_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (!t2_pwm && t2_wrap_evt) |=> bus_rdata[POS_T2_OVF]);

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == 8'h00 && irq_req == '0));

endmodule

// File: tb/tb_tif_flag_reg.sv
module tb_tif_flag_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       t0_pwm = 1'b0, t2_pwm = 1'b0, gie = 1'b0;
    logic [8:0] ev = '0;
    logic [6:0] irq_en = '0, irq_ack = '0, irq_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // ev bits: 0 t0_cmp, 1 t0_wrap, 2 t0_leave0, 3 t2_cmp, 4 t1_capt,
    //          5 t2_wrap, 6 t2_leave0, 7 t1_cmpb, 8 t1_cmpa
    tif_flag_reg dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .t0_cmp_evt(ev[0]), .t0_wrap_evt(ev[1]), .t0_leave0_evt(ev[2]),
        .t0_pwm(t0_pwm),
        .t1_cmpa_evt(ev[8]), .t1_cmpb_evt(ev[7]), .t1_capt_evt(ev[4]),
        .t2_cmp_evt(ev[3]), .t2_wrap_evt(ev[5]), .t2_leave0_evt(ev[6]),
        .t2_pwm(t2_pwm),
        .irq_en(irq_en), .gie(gie), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    // vector: {pwm0, pwm2, ev[8:0], we, wdata[7:0], ack[6:0], exp[7:0]}
    localparam int NV = 17;
    localparam logic [34:0] VEC [NV] = '{
        {2'b00, 9'h001, 1'b0, 8'h00, 7'h00, 8'h01},  // R1 t0 compare
        {2'b00, 9'h100, 1'b0, 8'h00, 7'h00, 8'h41},  // R1 t1 compare A
        {2'b00, 9'h088, 1'b0, 8'h00, 7'h00, 8'h65},  // R1 t1 cmpB + t2 cmp
        {2'b00, 9'h010, 1'b0, 8'h00, 7'h00, 8'h6D},  // R1 capture
        {2'b00, 9'h004, 1'b0, 8'h00, 7'h00, 8'h6D},  // R7 leave0 ignored
        {2'b00, 9'h002, 1'b0, 8'h00, 7'h00, 8'h6F},  // R7 t0 wrap
        {2'b00, 9'h020, 1'b0, 8'h00, 7'h00, 8'h7F},  // R7 t2 wrap
        {2'b00, 9'h000, 1'b1, 8'h00, 7'h00, 8'h7F},  // R2 write zero
        {2'b00, 9'h000, 1'b1, 8'h81, 7'h00, 8'h7E},  // R2 R9 write bit7+bit0
        {2'b00, 9'h000, 1'b0, 8'h00, 7'h40, 8'h3E},  // R3 ack bit6
        {2'b00, 9'h008, 1'b1, 8'h3E, 7'h00, 8'h04},  // R4 write vs set
        {2'b00, 9'h008, 1'b0, 8'h00, 7'h04, 8'h04},  // R4 ack vs set
        {2'b00, 9'h000, 1'b0, 8'h00, 7'h04, 8'h00},  // R3 ack bit2
        {2'b11, 9'h022, 1'b0, 8'h00, 7'h00, 8'h00},  // R8 wraps ignored
        {2'b11, 9'h004, 1'b0, 8'h00, 7'h00, 8'h02},  // R8 t0 leave0
        {2'b11, 9'h040, 1'b0, 8'h00, 7'h00, 8'h12},  // R8 t2 leave0
        {2'b00, 9'h000, 1'b1, 8'hFF, 7'h00, 8'h00}   // R2 R9 clear all
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        check("R10 reset flags", bus_rdata, 8'h00);
        check("R10 reset irq", {1'b0, irq_req}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            t0_pwm    = VEC[k][34];
            t2_pwm    = VEC[k][33];
            ev        = VEC[k][32:24];
            bus_we    = VEC[k][23];
            bus_wdata = VEC[k][22:15];
            irq_ack   = VEC[k][14:8];
            step();
            ev = '0; bus_we = 1'b0; bus_wdata = 8'h00; irq_ack = '0;
            check($sformatf("table %0d R1/R2/R3/R4/R7/R8/R9", k), bus_rdata, VEC[k][7:0]);
        end
        t0_pwm = 1'b0; t2_pwm = 1'b0;

        // R5 request follows flag by one edge
        gie = 1'b1; irq_en = 7'h01;
        ev[0] = 1'b1;
        step();
        ev = '0;
        check("R5 flag set", bus_rdata, 8'h01);
        check("R5 irq lags", {1'b0, irq_req}, 8'h00);
        step();
        check("R5 irq high", {1'b0, irq_req}, 8'h01);

        // R6 global enable drop
        gie = 1'b0;
        step();
        check("R6 gie drop", {1'b0, irq_req}, 8'h00);
        gie = 1'b1;
        step();
        check("R5 gie back", {1'b0, irq_req}, 8'h01);

        // R6 per-flag enable drop
        irq_en = 7'h00;
        step();
        check("R6 en drop", {1'b0, irq_req}, 8'h00);
        irq_en = 7'h7F;
        step();
        check("R5 en back", {1'b0, irq_req}, 8'h01);

        // R6 flag cleared by write
        bus_we = 1'b1; bus_wdata = 8'h01;
        step();
        bus_we = 1'b0; bus_wdata = 8'h00;
        check("R2 flag cleared", bus_rdata, 8'h00);
        step();
        check("R6 irq after clear", {1'b0, irq_req}, 8'h00);

        // R5 enables without flags give no request
        step();
        check("R5 no flag no irq", {1'b0, irq_req}, 8'h00);

        // R5 R1 second flag, then R10 reset while pending
        ev[8] = 1'b1; ev[4] = 1'b1;
        step();
        ev = '0;
        step();
        check("R5 irq cap+cmpA", {1'b0, irq_req}, 8'h48);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R10 reset flags pending", bus_rdata, 8'h00);
        check("R10 reset irq pending", {1'b0, irq_req}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule